// File: doc/BRIEF.md
# Analog comparator control and status register

This block is the digital side of an on-chip analog comparator. It holds one byte-wide control and status register on a small register bus. The bus has a select, a write strobe, write data and read data. The register contents drive the comparator's power-down line, the choice of positive source (internal reference or dedicated pin) and the choice of negative source. The negative source is either the dedicated pin or one of twelve shared channels, picked by an external multiplexer-enable input and a 4-bit channel code.

The raw comparator bit is first gated to 0 while the comparator is powered down. It then passes through a two-stage synchronizer, and the synchronized value is readable in the register. A 2-bit mode field picks which change of the synchronized value counts as an event. An event sets a sticky flag. The flag is cleared either by an interrupt-vector acknowledge pulse or by writing a 1 to its bit. The interrupt request is raised while the flag, the local enable and an external global enable are all high.

Powering the comparator down or up changes its gated output, so it can produce an event. This is deliberate and matches the behaviour of the analog part. Software is expected to disable the interrupt around such changes.

Top module: `acmp_ctrl`

## Requirements
- R1: After synchronous reset, the register reads 0x00, irq is 0, pwr_down is 0 and capture_en is 0.
- R2: While bus_sel is 1, a write with bus_we stores bits 7 (disable), 6 (reference select), 3 (interrupt enable), 2 (capture enable) and 1:0 (mode). Bit 5 ignores writes. bus_rdata is 0x00 while bus_sel is 0.
- R3: pwr_down equals register bit 7. While that bit is 1, the comparator value seen by the synchronizer is 0.
- R4: With bit 6 set to 1, pos_ref_sel is 1 and pos_pin_sel is 0. With bit 6 at 0, the two values are reversed.
- R5: When mux_en is 0, neg_pin_sel is 1, chan_onehot is all zero and sel_invalid is 0, whatever chan_code is.
- R6: When mux_en is 1, channel codes 0 to 11 set the single bit chan_onehot[code] and clear neg_pin_sel. Codes 12 to 15 set sel_invalid and select nothing.
- R7: Register bit 5 shows raw_cmp two clock edges after the raw input changes.
- R8: An event is detected on a change of the synchronized value and sets the flag (bit 4) one edge after bit 5 changes. Which changes count is set by the mode field (bits 1:0):
  - mode 00: any change;
  - mode 10: a 1 to 0 change;
  - mode 11: a 0 to 1 change;
  - mode 01: no change counts.
- R9: Writing a 1 to bit 4 clears the flag. Writing 0 to bit 4 leaves it unchanged.
- R10: A vec_ack pulse clears the flag. When an event and a clear fall on the same edge, the flag is set.
- R11: irq is 1 exactly when the flag, bit 3 and gie are all 1.
- R12: With raw_cmp held at 1 and mode 00, setting bit 7 sets the flag three edges after the write edge.
- R13: capture_en equals register bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register select (address decode) |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when not selected |
| raw_cmp | input | 1 | Raw comparator result |
| mux_en | input | 1 | Negative-input multiplexer enable |
| chan_code | input | 4 | Shared channel code |
| gie | input | 1 | Global interrupt enable |
| vec_ack | input | 1 | Interrupt vector acknowledge pulse |
| irq | output | 1 | Interrupt request |
| pwr_down | output | 1 | Comparator power-down |
| pos_ref_sel | output | 1 | Positive input from internal reference |
| pos_pin_sel | output | 1 | Positive input from dedicated pin |
| neg_pin_sel | output | 1 | Negative input from dedicated pin |
| chan_onehot | output | 12 | Shared channel select, one-hot |
| sel_invalid | output | 1 | Channel code selects nothing |
| capture_en | output | 1 | Input-capture enable |

## Verification
Register fields, select outputs and irq follow a write or an input change within the same cycle, so they are due at the first falling edge after the write edge. Bit 5 is due two rising edges after a raw change. The flag is due three rising edges after a raw change, or three after the write edge of the disable bit, and an acknowledge or a write-one clear lands on the next edge. The bench drives every input on a falling edge and samples on a later falling edge exactly that many edges on. It also samples one edge early, to show that bit 5 and the flag have not yet moved.

// File: rtl/acmp_pkg.sv
package acmp_pkg;

    localparam int REG_W    = 8;
    localparam int BIT_DIS  = 7;
    localparam int BIT_REF  = 6;
    localparam int BIT_OUT  = 5;
    localparam int BIT_FLAG = 4;
    localparam int BIT_IE   = 3;
    localparam int BIT_CAP  = 2;

    typedef enum logic [1:0] {
        MODE_TOGGLE = 2'b00,
        MODE_RSVD   = 2'b01,
        MODE_FALL   = 2'b10,
        MODE_RISE   = 2'b11
    } acmp_mode_e;

    typedef struct packed {
        logic       dis;
        logic       ref_sel;
        logic       ie;
        logic       cap;
        acmp_mode_e mode;
    } acmp_ctl_t;

    function automatic acmp_ctl_t ctl_from_bus(input logic [REG_W-1:0] w);
        acmp_ctl_t c;
        c.dis     = w[BIT_DIS];
        c.ref_sel = w[BIT_REF];
        c.ie      = w[BIT_IE];
        c.cap     = w[BIT_CAP];
        c.mode    = acmp_mode_e'(w[1:0]);
        return c;
    endfunction

    function automatic logic [REG_W-1:0] reg_image(input acmp_ctl_t c,
                                                   input logic outv,
                                                   input logic flag);
        logic [REG_W-1:0] r;
        r           = '0;
        r[BIT_DIS]  = c.dis;
        r[BIT_REF]  = c.ref_sel;
        r[BIT_OUT]  = outv;
        r[BIT_FLAG] = flag;
        r[BIT_IE]   = c.ie;
        r[BIT_CAP]  = c.cap;
        r[1:0]      = c.mode;
        return r;
    endfunction

    function automatic logic mode_event(input acmp_mode_e m,
                                        input logic cur,
                                        input logic prev);
        logic hit;
        case (m)
            MODE_TOGGLE: hit = cur ^ prev;
            MODE_FALL:   hit = prev & ~cur;
            MODE_RISE:   hit = cur & ~prev;
            default:     hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/acmp_sync.sv
module acmp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic cur,
    output logic prev
);
    logic [STAGES-1:0] stg;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[0] <= 1'b0;
                    else     stg[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[i] <= 1'b0;
                    else     stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= stg[STAGES-1];
    end

    assign cur = stg[STAGES-1];
endmodule

// File: rtl/acmp_flag.sv
module acmp_flag
    import acmp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  acmp_mode_e mode,
    input  logic       cur,
    input  logic       prev,
    input  logic       clr_write,
    input  logic       clr_ack,
    output logic       ev_hit,
    output logic       flag_q
);
    logic clr_any;

    assign ev_hit  = mode_event(mode, cur, prev);
    assign clr_any = clr_write | clr_ack;

    always_ff @(posedge clk) begin
        if (rst)          flag_q <= 1'b0;
        else if (ev_hit)  flag_q <= 1'b1;
        else if (clr_any) flag_q <= 1'b0;
    end
endmodule

// File: rtl/acmp_insel.sv
module acmp_insel #(
    parameter int NUM_CHAN = 12,
    parameter int CODE_W   = 4
) (
    input  logic                ref_sel,
    input  logic                mux_en,
    input  logic [CODE_W-1:0]   chan_code,
    output logic                pos_ref_sel,
    output logic                pos_pin_sel,
    output logic                neg_pin_sel,
    output logic [NUM_CHAN-1:0] chan_onehot,
    output logic                sel_invalid
);
    logic code_ok;

    assign code_ok     = int'(chan_code) < NUM_CHAN;
    assign pos_ref_sel = ref_sel;
    assign pos_pin_sel = ~ref_sel;
    assign neg_pin_sel = ~mux_en;
    assign sel_invalid = mux_en & ~code_ok;

    generate
        for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
            assign chan_onehot[c] = mux_en && (chan_code == CODE_W'(c));
        end
    endgenerate
endmodule

// File: rtl/acmp_ctrl.sv
module acmp_ctrl
    import acmp_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int NUM_CHAN    = 12,
    parameter int CODE_W      = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [REG_W-1:0]    bus_wdata,
    output logic [REG_W-1:0]    bus_rdata,
    input  logic                raw_cmp,
    input  logic                mux_en,
    input  logic [CODE_W-1:0]   chan_code,
    input  logic                gie,
    input  logic                vec_ack,
    output logic                irq,
    output logic                pwr_down,
    output logic                pos_ref_sel,
    output logic                pos_pin_sel,
    output logic                neg_pin_sel,
    output logic [NUM_CHAN-1:0] chan_onehot,
    output logic                sel_invalid,
    output logic                capture_en
);
    acmp_ctl_t ctl_q;
    logic      wr_en;
    logic      raw_eff;
    logic      out_cur;
    logic      out_prev;
    logic      ev_hit;
    logic      flag_q;

    assign wr_en = bus_sel & bus_we;

    always_ff @(posedge clk) begin
        if (rst)        ctl_q <= '0;
        else if (wr_en) ctl_q <= ctl_from_bus(bus_wdata);
    end

    // A powered-down comparator drives 0; edges caused by this are kept.
    assign raw_eff = raw_cmp & ~ctl_q.dis;

    acmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_eff),
        .cur  (out_cur),
        .prev (out_prev)
    );

    acmp_flag u_flag (
        .clk       (clk),
        .rst       (rst),
        .mode      (ctl_q.mode),
        .cur       (out_cur),
        .prev      (out_prev),
        .clr_write (wr_en & bus_wdata[BIT_FLAG]),
        .clr_ack   (vec_ack),
        .ev_hit    (ev_hit),
        .flag_q    (flag_q)
    );

    acmp_insel #(.NUM_CHAN(NUM_CHAN), .CODE_W(CODE_W)) u_insel (
        .ref_sel     (ctl_q.ref_sel),
        .mux_en      (mux_en),
        .chan_code   (chan_code),
        .pos_ref_sel (pos_ref_sel),
        .pos_pin_sel (pos_pin_sel),
        .neg_pin_sel (neg_pin_sel),
        .chan_onehot (chan_onehot),
        .sel_invalid (sel_invalid)
    );

    assign irq        = flag_q & ctl_q.ie & gie;
    assign pwr_down   = ctl_q.dis;
    assign capture_en = ctl_q.cap;
    assign bus_rdata  = bus_sel ? reg_image(ctl_q, out_cur, flag_q) : '0;
endmodule

// File: rtl/acmp_ctrl_chk.sv
module acmp_ctrl_chk #(
    parameter int NUM_CHAN = 12
) (
    input logic                clk,
    input logic                rst,
    input logic                bus_sel,
    input logic                bus_we,
    input logic [7:0]          bus_wdata,
    input logic [7:0]          bus_rdata,
    input logic                mux_en,
    input logic                vec_ack,
    input logic                pwr_down,
    input logic                neg_pin_sel,
    input logic [NUM_CHAN-1:0] chan_onehot,
    input logic                sel_invalid,
    input logic                ev_hit,
    input logic                flag_q
);
    assert_onehot_chan_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(chan_onehot));

    assert_invalid_none_R6: assert property (@(posedge clk) disable iff (rst)
        sel_invalid |-> (chan_onehot == '0) && !neg_pin_sel);

    assert_pin_default_R5: assert property (@(posedge clk) disable iff (rst)
        !mux_en |-> neg_pin_sel && !sel_invalid && (chan_onehot == '0));

    assert_ack_clears_R10: assert property (@(posedge clk) disable iff (rst)
        (vec_ack && !ev_hit) |=> !flag_q);

    assert_w1c_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_we && bus_wdata[4] && !ev_hit) |=> !flag_q);

    assert_event_wins_R10: assert property (@(posedge clk) disable iff (rst)
        ev_hit |=> flag_q);

    assert_flag_source_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(ev_hit));

    assert_pwr_view_R3: assert property (@(posedge clk) disable iff (rst)
        bus_sel |-> (bus_rdata[7] == pwr_down));
endmodule

bind acmp_ctrl acmp_ctrl_chk #(.NUM_CHAN(NUM_CHAN)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_sel     (bus_sel),
    .bus_we      (bus_we),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .mux_en      (mux_en),
    .vec_ack     (vec_ack),
    .pwr_down    (pwr_down),
    .neg_pin_sel (neg_pin_sel),
    .chan_onehot (chan_onehot),
    .sel_invalid (sel_invalid),
    .ev_hit      (ev_hit),
    .flag_q      (flag_q)
);

// File: tb/test_acmp_ctrl.sv
module test_acmp_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_sel, bus_we;
    logic [7:0]  bus_wdata, bus_rdata;
    logic        raw_cmp, mux_en, gie, vec_ack;
    logic [3:0]  chan_code;
    logic        irq, pwr_down, pos_ref_sel, pos_pin_sel, neg_pin_sel;
    logic [11:0] chan_onehot;
    logic        sel_invalid, capture_en;

    int nvec = 0;
    int nbad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acmp_ctrl i_acmp_ctrl (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .raw_cmp(raw_cmp),
        .mux_en(mux_en), .chan_code(chan_code), .gie(gie), .vec_ack(vec_ack),
        .irq(irq), .pwr_down(pwr_down), .pos_ref_sel(pos_ref_sel),
        .pos_pin_sel(pos_pin_sel), .neg_pin_sel(neg_pin_sel),
        .chan_onehot(chan_onehot), .sel_invalid(sel_invalid),
        .capture_en(capture_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        bus_we = 1'b1; bus_wdata = d;
        step(1);
        bus_we = 1'b0; bus_wdata = 8'h00;
    endtask

    task automatic t_reset();
        rst = 1'b1; step(3); rst = 1'b0; step(1);
        chk("R1 reg", bus_rdata, 8'h00);
        chk("R1 irq", irq, 0);
        chk("R1 pwr_down", pwr_down, 0);
        chk("R1 capture_en", capture_en, 0);
    endtask

    task automatic t_rw();
        wr(8'h6F);
        chk("R2 readback", bus_rdata, 8'h4F);
        chk("R13 capture_en", capture_en, 1);
        chk("R4 ref", {pos_ref_sel, pos_pin_sel}, 2'b10);
        bus_sel = 1'b0; #1;
        chk("R2 unselected", bus_rdata, 8'h00);
        bus_sel = 1'b1; #1;
        wr(8'h00);
        chk("R4 pin", {pos_ref_sel, pos_pin_sel}, 2'b01);
        chk("R13 capture off", capture_en, 0);
    endtask

    task automatic t_insel();
        mux_en = 1'b0;
        for (int c = 0; c < 16; c += 5) begin
            chan_code = 4'(c); #1;
            chk("R5 pin", {neg_pin_sel, sel_invalid, chan_onehot}, {2'b10, 12'h000});
        end
        mux_en = 1'b1;
        for (int c = 0; c < 16; c++) begin
            chan_code = 4'(c); #1;
            if (c < 12)
                chk("R6 chan", {neg_pin_sel, sel_invalid, chan_onehot},
                    {2'b00, 12'(12'h001 << c)});
            else
                chk("R6 invalid", {neg_pin_sel, sel_invalid, chan_onehot}, {2'b01, 12'h000});
        end
        mux_en = 1'b0;
    endtask

    task automatic t_mode(input logic [1:0] m, input logic from_v, input logic to_v,
                          input logic exp_flag);
        raw_cmp = from_v; step(4);
        wr(8'h10 | {6'd0, m});
        raw_cmp = to_v;
        step(1);
        chk("R7 early", bus_rdata[5], from_v);
        step(1);
        chk("R7 out", bus_rdata[5], to_v);
        chk("R8 no flag yet", bus_rdata[4], 0);
        step(1);
        chk("R8 flag", bus_rdata[4], exp_flag);
    endtask

    task automatic t_modes();
        t_mode(2'b00, 0, 1, 1);
        t_mode(2'b00, 1, 0, 1);
        t_mode(2'b10, 1, 0, 1);
        t_mode(2'b10, 0, 1, 0);
        t_mode(2'b11, 0, 1, 1);
        t_mode(2'b11, 1, 0, 0);
        t_mode(2'b01, 0, 1, 0);
        t_mode(2'b01, 1, 0, 0);
    endtask

    task automatic t_clear_irq();
        t_mode(2'b00, 1, 0, 1);
        wr(8'h08);
        chk("R9 write zero keeps", bus_rdata[4], 1);
        gie = 1'b0; #1;
        chk("R11 gie low", irq, 0);
        gie = 1'b1; #1;
        chk("R11 all set", irq, 1);
        wr(8'h00);
        chk("R11 ie low", irq, 0);
        wr(8'h10);
        chk("R9 write one clears", bus_rdata[4], 0);
        t_mode(2'b00, 0, 1, 1);
        vec_ack = 1'b1; step(1); vec_ack = 1'b0;
        chk("R10 ack clears", bus_rdata[4], 0);
        raw_cmp = 1'b0; step(2);
        vec_ack = 1'b1; step(1); vec_ack = 1'b0;
        chk("R10 event wins", bus_rdata[4], 1);
    endtask

    task automatic t_disable();
        raw_cmp = 1'b1; gie = 1'b1;
        wr(8'h18); step(4);
        wr(8'h18);
        chk("R12 pre clear", {bus_rdata[4], irq}, 2'b00);
        chk("R3 on", bus_rdata[5], 1);
        wr(8'h88);
        chk("R3 pwr_down", pwr_down, 1);
        step(2);
        chk("R3 gated out", bus_rdata[5], 0);
        chk("R12 not yet", bus_rdata[4], 0);
        step(1);
        chk("R12 spurious flag", {bus_rdata[4], irq}, 2'b11);
    endtask

    initial begin
        rst = 1'b1; bus_sel = 1'b1; bus_we = 1'b0; bus_wdata = 8'h00;
        raw_cmp = 1'b0; mux_en = 1'b0; chan_code = 4'h0; gie = 1'b0; vec_ack = 1'b0;
        step(1);
        t_reset();
        t_rw();
        t_insel();
        t_modes();
        t_clear_irq();
        t_disable();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            nvec++; nbad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end
endmodule